// File: doc/BRIEF.md
# Paged Address Translator with Set-Associative Translation Cache

This block turns a 14-bit virtual address into a 12-bit physical address for 64-byte pages. The low 6 bits are the offset within the page and pass through unchanged. The upper 8 bits are the page number, which must be translated. The unit first searches a 16-entry translation cache, built as 4 sets of 4 ways. On a miss it reads a single page-table word from memory and, if that word is valid, installs it in the cache. If the word is invalid, the unit reports a page fault instead of a translation.

Requests arrive on a valid/ready channel, and results leave on a second valid/ready channel. Only one translation is in flight at a time. `req_ready` is high only while the unit is idle: no request is being processed and no response is waiting to be taken. A response is held, with every field stable, until `rsp_ready` is seen high at a clock edge. The downstream side may therefore apply back-pressure for any number of cycles.

The memory read port is plain. The unit raises `mem_rd_en` for exactly one cycle with the address. Memory answers with a one-cycle `mem_rd_valid` pulse and the data, at least one cycle later. The `flush` input and the `table_base` input are plain control pins.

Top module: `addr_xlate_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0. The translation cache is empty, and every per-set round-robin pointer is at way 0.
- R2: Virtual address fields are split as follows: offset in bits 5:0, set index in bits 7:6 and tag in bits 13:8. The page number is bits 13:6. A successful translation returns `{ppn, offset}`, with the offset copied from the request.
- R3: When the page is present in the translation cache, the response has `rsp_hit`=1 and `rsp_fault`=0, and no memory read is issued.
- R4: When the page is not present, exactly one memory read is issued. Its address is `table_base` plus the page number, wrapping modulo 2^12. The returned word has the valid flag in bit 6 and the physical page number in bits 5:0. If the word is valid, the response has `rsp_hit`=0, `rsp_fault`=0 and the translated address.
- R5: A fetched word whose bit 6 is 0 produces `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0. Nothing is installed, so a repeat of the same page reads memory again.
- R6: After a miss with a valid word, a later request for the same page hits, as long as that entry has not been evicted or flushed.
- R7: A refill goes to the lowest-numbered empty way of its set. If the set is full, the refill goes to the way named by that set's round-robin pointer, and the pointer then advances by one, wrapping from way 3 to way 0. A refill into an empty way does not move the pointer, and a flush does not reset it.
- R8: A one-cycle pulse on `flush` empties the whole translation cache, so every later request misses until pages are refilled. If a flush and a refill fall in the same cycle, the flush wins and nothing is installed.
- R9: `req_ready` is 0 while a request is in progress or a response is pending. `rsp_paddr`, `rsp_hit` and `rsp_fault` stay stable while `rsp_valid`=1 and `rsp_ready`=0.
- R10: Three fixed cases are expected. 0x0020 misses and maps to 0xA20 when the table maps page 0x00 to 0x28. 0x03D4 maps to 0x354 when page 0x0F maps to 0x0D, and hits once cached. 0x0B8F (page 0x2E, set 2, tag 0x0B) with an invalid table word faults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the translation cache |
| table_base | input | 12 | Physical base address of the page table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_vaddr | input | 14 | Virtual address of the request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 12 | Physical address, 0 on a fault |
| rsp_hit | output | 1 | Translation came from the cache |
| rsp_fault | output | 1 | Page-table word was invalid |
| mem_rd_en | output | 1 | One-cycle page-table read strobe |
| mem_rd_addr | output | 12 | Page-table word address |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 7 | Page-table word: bit 6 valid, bits 5:0 page |

## Verification
The three fixed addresses are run first. They separate a cold miss, a fault whose invalid word carries a non-zero page field, and a hit on a freshly refilled entry. A directed run of five pages in one set, followed by reuse of the first two, shows empty-way filling, the round-robin victim choice and pointer advance. A page-table base near the top of the address range makes upper page numbers wrap the read address.

Random requests are then drawn over a small pool of pages that share sets. They are mixed with random back-pressure, random memory latency and occasional flushes. The bench's own cache model predicts every hit flag, fault flag, address and memory read, so any replacement, flush or hold error shows up as a mismatch.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [2:0] {
    XS_IDLE,
    XS_LOOK,
    XS_FETCH,
    XS_WAIT,
    XS_RESP
  } xlt_state_e;
endpackage

// File: rtl/xlt_cache.sv
module xlt_cache #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             refill_en,
  input  logic [PPN_W-1:0] rf_ppn
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];
  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] victim;
  logic             set_full;

  // per-way tag comparators
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  assign lk_hit = |match;

  always_comb begin
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) lk_ppn = lk_ppn | ppn_q[lk_set][w];
    end
  end

  // victim: lowest empty way, else round-robin pointer
  always_comb begin
    set_full = &vld_q[lk_set];
    victim   = rr_q[lk_set];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[lk_set][w]) victim = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (refill_en) begin
      vld_q[lk_set][victim] <= 1'b1;
      if (set_full) begin
        rr_q[lk_set] <= (rr_q[lk_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[lk_set] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (refill_en && !flush) begin
      tag_q[lk_set][victim] <= lk_tag;
      ppn_q[lk_set][victim] <= rf_ppn;
    end
  end

  AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit); // R8
endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import xlt_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SET_W = 2,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int TAG_W = VPN_W - SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [SET_W-1:0] lk_set,
  output logic [TAG_W-1:0] lk_tag,
  input  logic             lk_hit,
  input  logic [PPN_W-1:0] lk_ppn,
  output logic             refill_en,
  output logic [PPN_W-1:0] rf_ppn,
  output logic [VPN_W-1:0] vpn,
  output logic             mem_rd_en,
  input  logic             mem_rd_valid,
  input  logic [PPN_W:0]   mem_rd_data
);
  xlt_state_e      state_q;
  logic [VA_W-1:0] vaddr_q;
  logic [PA_W-1:0] paddr_q;
  logic            hit_q;
  logic            fault_q;
  logic            pte_ok;

  assign vpn       = vaddr_q[VA_W-1:OFF_W];
  assign lk_set    = vpn[SET_W-1:0];
  assign lk_tag    = vpn[VPN_W-1:SET_W];
  assign pte_ok    = mem_rd_data[PPN_W];
  assign rf_ppn    = mem_rd_data[PPN_W-1:0];
  assign refill_en = (state_q == XS_WAIT) && mem_rd_valid && pte_ok;
  assign mem_rd_en = (state_q == XS_FETCH);
  assign req_ready = (state_q == XS_IDLE);
  assign rsp_valid = (state_q == XS_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_hit   = hit_q;
  assign rsp_fault = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      vaddr_q <= '0;
      paddr_q <= '0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          state_q <= XS_LOOK;
        end
        XS_LOOK: if (lk_hit) begin
          paddr_q <= {lk_ppn, vaddr_q[OFF_W-1:0]};
          hit_q   <= 1'b1;
          fault_q <= 1'b0;
          state_q <= XS_RESP;
        end else begin
          state_q <= XS_FETCH;
        end
        XS_FETCH: state_q <= XS_WAIT;
        XS_WAIT: if (mem_rd_valid) begin
          hit_q   <= 1'b0;
          fault_q <= !pte_ok;
          paddr_q <= pte_ok ? {rf_ppn, vaddr_q[OFF_W-1:0]} : '0;
          state_q <= XS_RESP;
        end
        XS_RESP: if (rsp_ready) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit) && $stable(rsp_fault)); // R9

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_fault)); // R5

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0); // R5

  AST_READ_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !lk_hit); // R3

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R4

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]); // R2
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - SET_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PA_W-1:0] table_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_hit,
  output logic            rsp_fault,
  output logic            mem_rd_en,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [PPN_W:0]  mem_rd_data
);
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic             refill_en;
  logic [PPN_W-1:0] rf_ppn;
  logic [VPN_W-1:0] vpn;

  assign mem_rd_addr = table_base + PA_W'(vpn);

  xlt_ctrl #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .OFF_W(OFF_W),
    .SET_W(SET_W)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_paddr   (rsp_paddr),
    .rsp_hit     (rsp_hit),
    .rsp_fault   (rsp_fault),
    .lk_set      (lk_set),
    .lk_tag      (lk_tag),
    .lk_hit      (lk_hit),
    .lk_ppn      (lk_ppn),
    .refill_en   (refill_en),
    .rf_ppn      (rf_ppn),
    .vpn         (vpn),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_data (mem_rd_data)
  );

  xlt_cache #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .PPN_W(PPN_W)
  ) cache_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_set   (lk_set),
    .lk_tag   (lk_tag),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .refill_en(refill_en),
    .rf_ppn   (rf_ppn)
  );
endmodule

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] PT_BASE = 12'hF80;

  logic        clk;
  logic        rst_n;
  logic        flush;
  logic [11:0] table_base;
  logic        req_valid;
  logic        req_ready;
  logic [13:0] req_vaddr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [11:0] rsp_paddr;
  logic        rsp_hit;
  logic        rsp_fault;
  logic        mem_rd_en;
  logic [11:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [6:0]  mem_rd_data;

  int total;
  int bad;
  int mem_reads;
  logic [11:0] last_mem_addr;

  bit          m_v   [4][4];
  logic [5:0]  m_tag [4][4];
  logic [5:0]  m_ppn [4][4];
  int          m_rr  [4];

  addr_xlate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .table_base(table_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [6:0] pte_of(input logic [7:0] vpn);
    logic [31:0] h;
    if (vpn == 8'h00) return {1'b1, 6'h28};
    if (vpn == 8'h0F) return {1'b1, 6'h0D};
    if (vpn == 8'h2E) return {1'b0, 6'h15};
    if (vpn[7:6] == 2'b11 && vpn[0]) return {1'b0, vpn[5:0]};
    h = 32'(vpn) * 13 + 5;
    return {1'b1, h[5:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_clear();
  endtask

  task automatic xlate(input logic [13:0] va, input string req);
    logic [7:0]  vpn;
    logic [1:0]  set;
    logic [5:0]  tag;
    logic [11:0] e_pa;
    logic        e_hit;
    logic        e_fault;
    int          e_reads;
    int          r0;
    int          victim;
    logic [6:0]  p;
    logic [11:0] first_pa;
    logic [11:0] c_pa;
    logic        c_hit;
    logic        c_fault;
    bit          held;
    bit          ok9;
    vpn = va[13:6];
    set = vpn[1:0];
    tag = vpn[7:2];
    e_hit = 1'b0;
    e_fault = 1'b0;
    e_pa = '0;
    e_reads = 1;
    for (int w = 0; w < 4; w++) begin
      if (m_v[set][w] && m_tag[set][w] == tag) begin
        e_hit = 1'b1;
        e_pa = {m_ppn[set][w], va[5:0]};
        e_reads = 0;
      end
    end
    if (!e_hit) begin
      p = pte_of(vpn);
      if (p[6]) begin
        e_pa = {p[5:0], va[5:0]};
        victim = -1;
        for (int w = 0; w < 4; w++)
          if (!m_v[set][w] && victim < 0) victim = w;
        if (victim < 0) begin
          victim = m_rr[set];
          m_rr[set] = (m_rr[set] + 1) % 4;
        end
        m_v[set][victim] = 1'b1;
        m_tag[set][victim] = tag;
        m_ppn[set][victim] = p[5:0];
      end else begin
        e_fault = 1'b1;
      end
    end
    r0 = mem_reads;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = 14'($urandom);
    held = 1'b0;
    ok9 = 1'b1;
    first_pa = '0;
    forever begin
      rsp_ready = ($urandom % 3) != 0;
      if (rsp_valid) begin
        if (req_ready) ok9 = 1'b0;
        if (!held) begin
          first_pa = rsp_paddr;
          held = 1'b1;
        end else if (rsp_paddr != first_pa) begin
          ok9 = 1'b0;
        end
        if (rsp_ready) begin
          c_pa = rsp_paddr;
          c_hit = rsp_hit;
          c_fault = rsp_fault;
          break;
        end
      end
      @(negedge clk);
    end
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(c_pa == e_pa, req, "paddr", 32'(c_pa), 32'(e_pa));
    chk({c_hit, c_fault} == {e_hit, e_fault}, req, "hit/fault",
        32'({c_hit, c_fault}), 32'({e_hit, e_fault}));
    chk((mem_reads - r0) == e_reads, req, "mem reads", 32'(mem_reads - r0), 32'(e_reads));
    if (e_reads == 1)
      chk(last_mem_addr == 12'(PT_BASE + 12'(vpn)), "R4", "mem addr",
          32'(last_mem_addr), 32'(12'(PT_BASE + 12'(vpn))));
    chk(ok9, "R9", "hold/ready while pending", 32'(ok9), 32'd1);
  endtask

  // page-table memory model
  initial begin
    logic [11:0] a;
    logic [11:0] d;
    mem_rd_valid = 1'b0;
    mem_rd_data = '0;
    mem_reads = 0;
    last_mem_addr = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_en) begin
        a = mem_rd_addr;
        mem_reads++;
        last_mem_addr = a;
        repeat (1 + ($urandom % 3)) @(negedge clk);
        d = a - PT_BASE;
        mem_rd_data = pte_of(d[7:0]);
        mem_rd_valid = 1'b1;
        @(negedge clk);
        mem_rd_valid = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] vpn;
    int idx;
    void'($urandom(32'd20240611));
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    flush = 1'b0;
    table_base = PT_BASE;
    req_valid = 1'b0;
    req_vaddr = '0;
    rsp_ready = 1'b0;
    model_clear();
    for (int s = 0; s < 4; s++) m_rr[s] = 0;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_rd_en == 1'b0, "R1", "mem_rd_en", 32'(mem_rd_en), 32'd0);
    rst_n = 1'b1;

    // fixed cases
    xlate(14'h0020, "R10");
    xlate(14'h0020, "R6");
    xlate(14'h03D4, "R4");
    xlate(14'h03D4, "R10");
    xlate(14'h03C0, "R2");
    xlate(14'h03FF, "R3");
    xlate(14'h0B8F, "R10");
    xlate(14'h0B80, "R5");

    // replacement in set 1: five pages, then reuse
    for (int t = 0; t < 5; t++) xlate({6'(8'h10 + t), 2'b01, 6'(t * 7)}, "R7");
    xlate({6'h11, 2'b01, 6'h01}, "R7");
    xlate({6'h10, 2'b01, 6'h02}, "R7");
    xlate({6'h11, 2'b01, 6'h03}, "R7");
    xlate({6'h14, 2'b01, 6'h04}, "R7");

    // flush empties cache
    do_flush();
    xlate(14'h03D4, "R8");
    xlate(14'h0020, "R8");
    xlate(14'h03D4, "R6");

    // upper pages wrap table address
    xlate({8'hC4, 6'h11}, "R4");
    xlate({8'hC5, 6'h22}, "R5");

    // random mix
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 40) == 0) do_flush();
      idx = $urandom % 20;
      vpn = 8'((idx * 37) ^ (idx << 2));
      xlate({vpn, 6'($urandom)}, "R7");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule